// File: doc/BRIEF.md
# Modem Line Status and Control Register Unit

This unit holds the modem control and modem status registers of a 16550-style serial port. Four external handshake lines are sampled into the clock domain: clear-to-send, data-set-ready, carrier-detect and ring. The unit keeps their current levels and records every change in sticky change flags. A read of the status register hands software the levels and the flags in one byte and then clears the flags. While any flag is set, a level output tells the interrupt logic that modem status has changed.

The control register drives the four handshake outputs and holds a loopback bit. With loopback set, the handshake outputs are routed back inside the unit in place of the external inputs. Software can then exercise the status path without a cable. Changes made through loopback set the change flags in the same way as external changes.

Access is through a one-bit register select with separate read and write strobes. Read data is combinational.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, the control register reads 0x08 (only OUT2 set), the status register reads 0xB0 (DCD, DSR and CTS high, all change flags clear), and anyDelta is low.
- R2: A write with regSel=0 stores wrData[4:0] in the control register, with bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2 and bit4 loopback. Reading it returns zeros in bits 7:5. The pins dtrOut, rtsOut, out1Out and out2Out follow bits 0 to 3.
- R3: The status register (regSel=1) holds DCD in bit7, RI in bit6, DSR in bit5 and CTS in bit4. When loopback is off, a change on an external input appears there at the third rising clock edge after the change.
- R4: Bit3 (DCD), bit1 (DSR) and bit0 (CTS) are change flags. Each is set when its line changes in either direction, and it stays set until the status register is read.
- R5: Bit2 is the trailing-edge ring flag. It is set only when RI goes from 1 to 0, and never when RI goes from 0 to 1.
- R6: A status read returns the value held before the clock edge and clears bits 3:0 at that edge. A line change detected at the same edge still sets its flag, so setting takes priority over clearing.
- R7: anyDelta is high exactly when status bits 3:0 are not all zero.
- R8: With loopback set, the status line bits are fed from the control register and the external inputs are ignored. Bit7 takes OUT2, bit6 takes OUT1, bit5 takes DTR and bit4 takes RTS. The new levels appear one edge after the control write, and the resulting transitions set the change flags.
- R9: A write with regSel=1 has no effect on either register. A read with regSel=0 leaves the change flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | 0 selects control register, 1 selects status register |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (status read clears change flags) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| ctsIn | input | 1 | External clear-to-send, high = asserted |
| dsrIn | input | 1 | External data-set-ready, high = asserted |
| dcdIn | input | 1 | External carrier detect, high = asserted |
| riIn | input | 1 | External ring indicator, high = asserted |
| dtrOut | output | 1 | Data-terminal-ready output (control bit0) |
| rtsOut | output | 1 | Request-to-send output (control bit1) |
| out1Out | output | 1 | User output 1 (control bit2) |
| out2Out | output | 1 | User output 2 (control bit3) |
| anyDelta | output | 1 | High while any status change flag is set |

## Verification
A status read and the detection of a new line change can fall on the same clock edge: the read wants to clear the flags while the change wants to set one. The bench sets up this collision on purpose. It first sets the DSR flag with a settled change. It then toggles CTS and places the status read exactly on the third edge after that toggle. The byte returned must show the old levels with only the DSR flag set. A second read must show the new CTS level with only the CTS flag, which proves that the read cleared the old flag and the new one survived.

// File: rtl/msr_pkg.sv
package msr_pkg;

  // Handshake line levels, ordered as they sit in status bits 7:4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modemLines_t;

  // Strobes from the access decoder to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic rdStatus;
    logic selStatus;
  } msrStrobe_t;

  localparam int CTRL_W   = 5;
  localparam int DATA_W   = 8;
  localparam int LINE_W   = 4;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b01000;
  localparam modemLines_t LINES_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic       regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  output msrStrobe_t strobe
);

  always_comb begin
    strobe.wrCtrl    = wrEn & ~regSel;
    strobe.rdStatus  = rdEn & regSel;
    strobe.selStatus = regSel;
  end

endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  msrStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  modemLines_t        extLines,
  output logic [DATA_W-1:0]  rdData,
  output logic [CTRL_W-1:0]  ctrlQ,
  output modemLines_t        lineQ,
  output logic [LINE_W-1:0]  deltaQ
);

  localparam int PAD_W = DATA_W - CTRL_W;

  modemLines_t syncOut;
  modemLines_t loopLines;
  modemLines_t srcLines;
  logic [LINE_W-1:0] newDelta;

  // Input synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0][LINE_W-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= LINES_RESET;
        end else begin
          syncQ[0] <= extLines;
          for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
        end
      end
      assign syncOut = syncQ[SYNC_STAGES-1];
    end else begin : g_nosync
      assign syncOut = extLines;
    end
  endgenerate

  // Loopback routing: OUT2->DCD, OUT1->RI, DTR->DSR, RTS->CTS
  always_comb begin
    loopLines.dcd = ctrlQ[3];
    loopLines.ri  = ctrlQ[2];
    loopLines.dsr = ctrlQ[0];
    loopLines.cts = ctrlQ[1];
    srcLines      = ctrlQ[4] ? loopLines : syncOut;
    newDelta[3]   = lineQ.dcd ^ srcLines.dcd;
    newDelta[2]   = lineQ.ri & ~srcLines.ri;
    newDelta[1]   = lineQ.dsr ^ srcLines.dsr;
    newDelta[0]   = lineQ.cts ^ srcLines.cts;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RESET;
      lineQ  <= LINES_RESET;
      deltaQ <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
      lineQ  <= srcLines;
      deltaQ <= (strobe.rdStatus ? '0 : deltaQ) | newDelta;
    end
  end

  assign rdData = strobe.selStatus ? {lineQ, deltaQ} : {{PAD_W{1'b0}}, ctrlQ};

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       dcdIn,
  input  logic       riIn,
  output logic       dtrOut,
  output logic       rtsOut,
  output logic       out1Out,
  output logic       out2Out,
  output logic       anyDelta
);

  msrStrobe_t        strobe;
  modemLines_t       extLines;
  modemLines_t       lineView;
  logic [CTRL_W-1:0] ctrlView;
  logic [LINE_W-1:0] deltaView;

  assign extLines = '{dcd: dcdIn, ri: riIn, dsr: dsrIn, cts: ctsIn};

  msr_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .extLines (extLines),
    .rdData   (rdData),
    .ctrlQ    (ctrlView),
    .lineQ    (lineView),
    .deltaQ   (deltaView)
  );

  assign dtrOut   = ctrlView[0];
  assign rtsOut   = ctrlView[1];
  assign out1Out  = ctrlView[2];
  assign out2Out  = ctrlView[3];
  assign anyDelta = |deltaView;

endmodule

// File: rtl/modem_status_unit_checker.sv
module modem_status_unit_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       anyDelta,
  input logic [4:0] ctrlView,
  input logic [3:0] lineView,
  input logic [3:0] deltaView
);

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel) |=> (ctrlView == $past(wrData[4:0])));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && regSel) |=> ((deltaView & $past(deltaView)) == $past(deltaView)));

  a_r5_teri_falling: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deltaView[2]) |-> $fell(lineView[2]));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel) |=> ((deltaView == 4'b0) || (lineView != $past(lineView))));

  a_r7_any_delta: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel) |-> (anyDelta == (rdData[3:0] != 4'b0)));

  a_r8_loop_route: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlView[4]) |->
      (lineView == {$past(ctrlView[3]), $past(ctrlView[2]), $past(ctrlView[0]), $past(ctrlView[1])}));

endmodule

bind modem_status_unit modem_status_unit_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .anyDelta  (anyDelta),
  .ctrlView  (ctrlView),
  .lineView  (lineView),
  .deltaView (deltaView)
);

// File: tb/modem_status_unit_bench.sv
module modem_status_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic ctsIn = 1'b1, dsrIn = 1'b1, dcdIn = 1'b1, riIn = 1'b0;
  logic dtrOut, rtsOut, out1Out, out2Out, anyDelta;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_unit u_modem_status_unit (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .out1Out(out1Out), .out2Out(out2Out),
    .anyDelta(anyDelta)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // lines nibble: bit3 DCD, bit2 RI, bit1 DSR, bit0 CTS
  task automatic setLines(input logic [3:0] v);
    {dcdIn, riIn, dsrIn, ctsIn} = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    regSel = sel;
    rdEn = 1'b1;
    #1 val = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    regSel = sel;
    wrEn = 1'b1;
    wrData = data;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [3:0] expDelta(input logic [3:0] p, input logic [3:0] n);
    return {p[3] ^ n[3], p[2] & ~n[2], p[1] ^ n[1], p[0] ^ n[0]};
  endfunction

  initial begin
    logic [7:0] val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 anyDelta", {7'b0, anyDelta}, 8'h00);
    readReg(1'b0, val); check("R1 ctrl", val, 8'h08);
    readReg(1'b1, val); check("R1 status", val, 8'hB0);

    // R3 R4 R5 R7: sweep every pair of line patterns
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        logic [3:0] d;
        setLines(p[3:0]); settle(); readReg(1'b1, val);
        setLines(n[3:0]); settle();
        d = expDelta(p[3:0], n[3:0]);
        check("R7 anyDelta", {7'b0, anyDelta}, {7'b0, (d != 4'b0)});
        readReg(1'b1, val);
        check("R3 R4 R5 status after change", val, {n[3:0], d});
      end
    end

    // R6 collision: read on the edge that detects a new change
    setLines(4'b1011); settle(); readReg(1'b1, val);
    setLines(4'b1001); settle();              // DSR flag set
    setLines(4'b1000);                        // CTS drops
    repeat (2) @(posedge clk);
    @(negedge clk);
    readReg(1'b1, val);
    check("R6 read at collision edge", val, 8'h92);
    readReg(1'b1, val);
    check("R6 new flag survives clear", val, 8'h81);

    // R9 status write ignored, control read does not clear
    setLines(4'b1011); settle(); readReg(1'b1, val);
    setLines(4'b0011); settle();
    writeReg(1'b1, 8'h00);
    readReg(1'b0, val); check("R9 ctrl after status write", val, 8'h08);
    readReg(1'b1, val); check("R9 flags kept after ctrl read", val, 8'h38);

    // R2 control write masks upper bits and drives pins
    writeReg(1'b0, 8'hEF);
    readReg(1'b0, val); check("R2 ctrl readback", val, 8'h0F);
    check("R2 pins", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h0F);

    // R8 loopback sweep with external inputs opposing
    for (int v = 0; v < 16; v++) begin
      logic [3:0] m;
      m = {v[3], v[2], v[0], v[1]};
      setLines(~m);
      writeReg(1'b0, 8'h10 | 8'(v));
      @(posedge clk); @(negedge clk);
      readReg(1'b1, val);
      check("R8 loopback lines", {4'b0, val[7:4]}, {4'b0, m});
      readReg(1'b0, val);
      check("R2 ctrl with loop", val, 8'h10 | 8'(v));
      check("R2 pins with loop", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'(v));
    end

    // R8 loopback transition sets its flag
    writeReg(1'b0, 8'h10);
    @(posedge clk); @(negedge clk);
    readReg(1'b1, val);
    writeReg(1'b0, 8'h12);
    @(posedge clk); @(negedge clk);
    readReg(1'b1, val);
    check("R8 loop RTS to CTS flag", val, 8'h11);

    writeReg(1'b0, 8'h08);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule